// File: doc/BRIEF.md
# Modem Status Change Tracker

This block keeps the modem status byte of a 16550-style serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator and carrier detect) enter asynchronously. They are synchronized, and their current levels are held in the upper nibble of the status byte. Each change of a line sets a sticky change flag in the lower nibble. For the ring indicator, the flag is set only on the trailing edge.

A host read of the status byte returns it and clears the change flags. A change that lands on the same clock edge as the read is kept. The block also holds a five-bit modem control byte. One bit of that byte selects a loopback view, in which a status read reports four control bits in place of the line levels. The interrupt request output is high while any change flag is set.

Top module: `mstat_tracker`

## Requirements
- R1: The status byte's upper nibble holds the synchronized line levels, with carrier detect in bit 7, ring in bit 6, data-set-ready in bit 5 and clear-to-send in bit 4. The input `line_in` carries the same order in bits 3..0. A level change on `line_in` shows in `stat_rdata` after the third rising clock edge.
- R2: A change flag (bit 3 for carrier detect, bit 1 for data-set-ready, bit 0 for clear-to-send) sets on the same edge as its level changes, for either direction of change.
- R3: The ring flag (bit 2) sets only when the ring level goes from 1 to 0, and never when it goes from 0 to 1.
- R4: Change flags are sticky until a read. A cycle with `stat_rd` high outside loopback clears all four flags at its closing edge and leaves the levels unchanged.
- R5: A line change whose flag would set on the same edge that a read clears the flags still leaves its flag set after that edge.
- R6: While control bit 4 is set, `stat_rdata` returns control bit 3 in bit 7, control bit 2 in bit 6, control bit 0 in bit 5, control bit 1 in bit 4, and zeros in bits 3..0. A read in this mode clears no flags.
- R7: After reset, `stat_rdata` reads 8'hB0, `irq` is low and `ctl_q` is zero.
- R8: A cycle with `ctl_wr` high stores `ctl_wdata[4:0]` into `ctl_q` at its closing edge. Bits 7..5 are dropped, and `ctl_q` holds its value otherwise.
- R9: `irq` is high exactly when at least one of the four change flags is set, including while loopback is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 4 | Raw modem lines {carrier, ring, set-ready, clear-to-send} |
| stat_rd | input | 1 | Status read strobe, one cycle per read |
| stat_rdata | output | 8 | Status byte, or loopback view |
| ctl_wr | input | 1 | Modem control write strobe |
| ctl_wdata | input | 8 | Modem control write data |
| ctl_q | output | 5 | Stored modem control bits |
| irq | output | 1 | Modem status interrupt request |

## Verification
A line change travels through two synchronizer flops and then the level register. Its level and change flag are therefore due after the third rising edge, and the bench checks both after two edges (nothing yet) and after three (updated). Read clearing and control writes take effect on the edge that closes the strobe cycle, so the bench samples `stat_rdata` combinationally during the strobe cycle and again at the falling edge after it. The sweep walks all 256 pairs of old and new line values and all 32 control values. The coincident read-and-change case is placed exactly on the third edge.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int LINES  = 4;
   localparam int CTL_W  = 5;
   localparam int BYTE_W = 8;

   // status line positions inside a nibble
   localparam int IDX_CTS  = 0;
   localparam int IDX_DSR  = 1;
   localparam int IDX_RING = 2;
   localparam int IDX_DCD  = 3;

   // control bit positions
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;

   typedef logic [LINES-1:0] line_vec_t;
   typedef logic [CTL_W-1:0] ctl_vec_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mstat_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mstat_sync needs a nonzero width");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

   AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q_o == $past(chain_q[STAGES-2])); // R1
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta #(
   parameter int LINES = 4,
   parameter logic [LINES-1:0] TRAIL_MASK = 4'b0100,
   parameter logic [LINES-1:0] RST_LVL = 4'b1011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lvl_i,
   input  logic             clr_i,
   output logic [LINES-1:0] lvl_o,
   output logic [LINES-1:0] delta_o
);
   logic [LINES-1:0] lvl_q;
   logic [LINES-1:0] delta_q;
   logic [LINES-1:0] hit;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (TRAIL_MASK[i]) begin : g_trail
         assign hit[i] = lvl_q[i] & ~lvl_i[i];
         AST_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(delta_q[i]) |-> $fell(lvl_q[i])); // R3
      end else begin : g_both
         assign hit[i] = lvl_q[i] ^ lvl_i[i];
         AST_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(delta_q[i]) |-> lvl_q[i] != $past(lvl_q[i])); // R2
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= RST_LVL;
         delta_q <= '0;
      end else begin
         lvl_q   <= lvl_i;
         delta_q <= (clr_i ? '0 : delta_q) | hit;
      end
   end

   assign lvl_o   = lvl_q;
   assign delta_o = delta_q;

   AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> lvl_q == $past(lvl_i)); // R1
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (delta_q & $past(delta_q)) == $past(delta_q)); // R4
   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && hit == '0) |=> delta_q == '0); // R4
   AST_KEEP_COINCIDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && hit != '0) |=> (delta_q & $past(hit)) == $past(hit)); // R5
endmodule

// File: rtl/mstat_ctl.sv
module mstat_ctl
   import mstat_pkg::*;
#(
   parameter logic [CTL_W-1:0] CTL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output ctl_vec_t          ctl_o,
   output logic              loop_o,
   output line_vec_t         loop_view_o
);
   ctl_vec_t ctl_q;
   logic     unused_hi;

   assign unused_hi = ^wdata_i[BYTE_W-1:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
      end else if (wr_i) begin
         ctl_q <= wdata_i[CTL_W-1:0];
      end
   end

   assign ctl_o  = ctl_q;
   assign loop_o = ctl_q[CB_LOOP];

   // control outputs folded back onto status line positions
   assign loop_view_o[IDX_DCD]  = ctl_q[CB_OUT2];
   assign loop_view_o[IDX_RING] = ctl_q[CB_OUT1];
   assign loop_view_o[IDX_DSR]  = ctl_q[CB_DTR];
   assign loop_view_o[IDX_CTS]  = ctl_q[CB_RTS];

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctl_q)); // R8
   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ctl_q == $past(wdata_i[CTL_W-1:0])); // R8
endmodule

// File: rtl/mstat_tracker.sv
module mstat_tracker
   import mstat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter logic [LINES-1:0] RESET_LEVELS = 4'b1011,
   parameter logic [LINES-1:0] TRAIL_MASK = 4'b0100,
   parameter logic [CTL_W-1:0] CTL_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  line_in,
   input  logic              stat_rd,
   output logic [BYTE_W-1:0] stat_rdata,
   input  logic              ctl_wr,
   input  logic [BYTE_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0]  ctl_q,
   output logic              irq
);
   if (2 * LINES != BYTE_W) begin : g_bad_layout
      $error("status byte must be two line nibbles");
   end

   line_vec_t sync_lvl;
   line_vec_t lvl;
   line_vec_t delta;
   line_vec_t loop_view;
   logic      loop_on;
   logic      rd_clr;

   mstat_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES),
      .RST_VAL(RESET_LEVELS)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (line_in),
      .q_o  (sync_lvl)
   );

   mstat_ctl #(
      .CTL_RST(CTL_RESET)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (ctl_wr),
      .wdata_i    (ctl_wdata),
      .ctl_o      (ctl_q),
      .loop_o     (loop_on),
      .loop_view_o(loop_view)
   );

   assign rd_clr = stat_rd & ~loop_on;

   mstat_delta #(
      .LINES     (LINES),
      .TRAIL_MASK(TRAIL_MASK),
      .RST_LVL   (RESET_LEVELS)
   ) u_delta (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sync_lvl),
      .clr_i  (rd_clr),
      .lvl_o  (lvl),
      .delta_o(delta)
   );

   always_comb begin
      if (loop_on) stat_rdata = {loop_view, {LINES{1'b0}}};
      else         stat_rdata = {lvl, delta};
   end

   assign irq = |delta;

   AST_LOOP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |-> stat_rdata[LINES-1:0] == '0); // R6
   AST_LOOP_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_on && irq) |=> irq); // R6
   AST_IRQ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_on |-> irq == (stat_rdata[LINES-1:0] != '0)); // R9
endmodule

// File: tb/sim_mstat_tracker.sv
module sim_mstat_tracker;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_in = 4'b1011;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [4:0] ctl_q;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   mstat_tracker u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .stat_rd(stat_rd),
      .stat_rdata(stat_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_q(ctl_q), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle3();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(output logic [7:0] val);
      stat_rd = 1'b1;
      #1 val = stat_rdata;
      @(posedge clk);
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(posedge clk);
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
      return ((a ^ b) & 4'b1011) | ({3'b000, a[2] & ~b[2]} << 2);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      chk("R7 rdata", stat_rdata, 8'hB0);
      chk("R7 irq", irq, 0);
      chk("R7 ctl", ctl_q, 0);

      // R1 R2 latency: nothing after two edges, updated after three
      line_in = 4'b1010;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 latency early", stat_rdata, 8'hB0);
      @(posedge clk);
      @(negedge clk);
      chk("R2 latency due", stat_rdata, 8'hA1);
      chk("R9 irq set", irq, 1);
      do_read(rv);
      chk("R4 read value", rv, 8'hA1);
      chk("R4 cleared keeps level", stat_rdata, 8'hA0);
      chk("R9 irq clear", irq, 0);

      // R4 sticky through toggle back
      line_in = 4'b1011;
      settle3();
      line_in = 4'b1010;
      settle3();
      chk("R4 sticky", stat_rdata, 8'hA1);
      do_read(rv);

      // R3 ring rising: no flag; falling: flag
      line_in = 4'b1110;
      settle3();
      chk("R3 ring rise", stat_rdata, 8'hE0);
      line_in = 4'b1010;
      settle3();
      chk("R3 ring fall", stat_rdata, 8'hA4);
      do_read(rv);

      // R5 change landing on the read's clearing edge
      line_in = 4'b1011;
      repeat (2) @(posedge clk);
      @(negedge clk);
      stat_rd = 1'b1;
      #1 chk("R5 pre-edge view", stat_rdata, 8'hA0);
      @(posedge clk);
      @(negedge clk);
      stat_rd = 1'b0;
      chk("R5 flag kept", stat_rdata, 8'hB1);
      do_read(rv);

      // R1 R2 R3 R9 sweep over all old/new pairs
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            line_in = a[3:0];
            settle3();
            do_read(rv);
            line_in = b[3:0];
            settle3();
            chk("R2 R3 sweep", stat_rdata, {b[3:0], exp_flags(a[3:0], b[3:0])});
            chk("R9 sweep irq", irq, exp_flags(a[3:0], b[3:0]) != 4'h0);
            do_read(rv);
         end
      end

      // R6 loopback read does not clear flags
      line_in = 4'b1011;
      settle3();
      do_read(rv);
      line_in = 4'b1001;
      settle3();
      write_ctl(8'h10);
      do_read(rv);
      chk("R6 loop view", rv, 8'h00);
      chk("R9 irq in loop", irq, 1);
      write_ctl(8'h00);
      chk("R6 flag survives", stat_rdata, 8'h92);
      do_read(rv);

      // R8 upper bits dropped
      write_ctl(8'hE3);
      chk("R8 mask", ctl_q, 5'h03);
      chk("R8 not loop", stat_rdata, 8'h90);

      // R6 R8 sweep of control values
      for (int v = 0; v < 32; v++) begin
         write_ctl({3'b101, v[4:0]});
         chk("R8 store", ctl_q, v[4:0]);
         if (v[4]) chk("R6 map", stat_rdata, {v[3], v[2], v[0], v[1], 4'b0000});
         else      chk("R6 normal", stat_rdata, 8'h90);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule